// File: doc/BRIEF.md
# Quadlet-fed nibble CRC-16 engine

This block computes the 16-bit check word that guards a block of serial-bus map or ROM data. A controller pulses `start_i` together with the number of 32-bit quadlets the block covers. It then presents the quadlets on `data_i` with `valid_i`, one quadlet per clock at most. Typical lengths are the self-ID count plus two for a topology block and 1009 for a speed block.

Each accepted quadlet goes through eight 4-bit feedback steps in one clock. The steps take the most significant nibble first. Each step uses a shift-and-XOR update, so no bit-serial shift register is needed. The result is the CRC-16 with polynomial 0x1021, initial value zero and no final inversion, taken over the quadlet bits from most significant to least significant.

One cycle after the last counted quadlet, the engine raises `done_o` for one clock and drives the result on `crc_o`. The result stays there until the next start.

Top module: `quad_crc16_gen`

## Requirements
- R1: A synchronous active-high `rst` forces `busy_o`=0, `done_o`=0 and `crc_o`=0 on the following edge, even when a block is in progress.
- R2: A `start_i` pulse loads the quadlet count from `len_i` and clears the running check. From the next cycle `busy_o` is 1 if `len_i` is non-zero, `crc_o` reads 0, and any quadlet offered in the start cycle is not consumed.
- R3: The final value equals an MSB-first CRC-16 with polynomial 0x1021, initial value 0 and no final XOR, computed over bits 31 down to 0 of each counted quadlet in arrival order.
- R4: While `busy_o` is 1, a quadlet is consumed on every clock with `valid_i`=1. Cycles with `valid_i`=0 consume nothing and leave the count unchanged.
- R5: `done_o` is a single-cycle pulse in the cycle after the last counted quadlet is accepted. `busy_o` is 0 in that same cycle, and `done_o` never rises before the count is used up.
- R6: After completion, `crc_o` holds its value until the next start. Quadlets presented with `valid_i`=1 while `busy_o` is 0 are ignored.
- R7: A start with `len_i`=0 gives a `done_o` pulse in the next cycle with `crc_o`=0.
- R8: A start while `busy_o` is 1 abandons the current block. The result then covers only quadlets accepted after the new start, counted against the new length.
- R9: Lengths up to 2^LEN_W-1 are supported; a 1009-quadlet block completes with the correct value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a new block, load length |
| len_i | input | LEN_W | Number of quadlets in the block |
| valid_i | input | 1 | `data_i` carries a quadlet this cycle |
| data_i | input | DATA_W | Quadlet to fold in |
| busy_o | output | 1 | Block in progress, quadlets still expected |
| done_o | output | 1 | One-cycle completion pulse |
| crc_o | output | CRC_W | Final check value, held until next start |

## Verification
The bench first walks a table of short blocks, some of them with idle cycles between quadlets. A design that counts stalled cycles or folds nibbles least-significant first returns a value that disagrees with the bit-serial reference.

The directed cases cover:
- A zero-length start. A wrong engine either hangs busy or never pulses done.
- Data offered while idle. A design that folds it would disturb the held result.
- A restart in mid-block. A design that keeps the old count or the old running value shows up here.
- A 1009-quadlet run. An early done or a counter that is too narrow gives an early pulse or a wrong value.
- A reset in mid-block. It must clear all outputs.

// File: rtl/qcrc_pkg.sv
package qcrc_pkg;
  localparam int CRC_W   = 16;
  localparam int NIB_W   = 4;
  localparam int TAP_HI  = 12;
  localparam int TAP_MID = 5;
  typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/qcrc_nibble_step.sv
module qcrc_nibble_step
  import qcrc_pkg::*;
(
  input  crc_t             crc_in,
  input  logic [NIB_W-1:0] nib,
  output crc_t             crc_out
);
  logic [NIB_W-1:0] sum;
  crc_t             sum_w;

  always_comb begin
    sum     = crc_in[CRC_W-1 -: NIB_W] ^ nib;
    sum_w   = crc_t'(sum);
    crc_out = (crc_in << NIB_W) ^ (sum_w << TAP_HI) ^ (sum_w << TAP_MID) ^ sum_w;
  end
endmodule

// File: rtl/qcrc_quad_fold.sv
module qcrc_quad_fold
  import qcrc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  crc_t              crc_in,
  input  logic [DATA_W-1:0] data,
  output crc_t              crc_out
);
  localparam int NSTEP = DATA_W / NIB_W;

  crc_t chain [NSTEP+1];

  assign chain[0] = crc_in;

  // most significant nibble enters first
  for (genvar g = 0; g < NSTEP; g++) begin : g_step
    qcrc_nibble_step u_step (
      .crc_in (chain[g]),
      .nib    (data[DATA_W-1-g*NIB_W -: NIB_W]),
      .crc_out(chain[g+1])
    );
  end

  assign crc_out = chain[NSTEP];
endmodule

// File: rtl/qcrc_len_ctrl.sv
module qcrc_len_ctrl #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             valid_i,
  output logic             accept_o,
  output logic             last_o,
  output logic             busy_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] remaining;

  assign accept_o = busy_o && valid_i && !start_i;
  assign last_o   = accept_o && (remaining == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      busy_o    <= 1'b0;
    end else if (start_i) begin
      remaining <= len_i;
      busy_o    <= (len_i != '0);
    end else if (accept_o) begin
      remaining <= remaining - ONE;
      if (remaining == ONE) busy_o <= 1'b0;
    end
  end

  // R4: stalled cycles leave the count alone
  assert_stall_keeps_count_R4: assert property (@(posedge clk) disable iff (rst)
    (!valid_i && !start_i) |=> $stable(remaining));

  // R2: busy after start matches non-zero length
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (busy_o == ($past(len_i) != '0)));
endmodule

// File: rtl/quad_crc16_gen.sv
module quad_crc16_gen
  import qcrc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CRC_W-1:0]  crc_o
);
  crc_t acc;
  crc_t acc_next;
  logic accept;
  logic last;

  qcrc_len_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .len_i   (len_i),
    .valid_i (valid_i),
    .accept_o(accept),
    .last_o  (last),
    .busy_o  (busy_o)
  );

  qcrc_quad_fold #(.DATA_W(DATA_W)) u_fold (
    .crc_in (acc),
    .data   (data_i),
    .crc_out(acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      crc_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= start_i ? (len_i == '0) : last;
      if (start_i) begin
        acc   <= '0;
        crc_o <= '0;
      end else if (accept) begin
        acc <= acc_next;
        if (last) crc_o <= acc_next;
      end
    end
  end

  // R5: completion is a single pulse
  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5: engine is idle when done is reported
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R6: idle engine holds its result
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !busy_o) |=> $stable(crc_o));

  // R2: start clears the presented value
  assert_start_clear_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (crc_o == '0));
endmodule

// File: tb/quad_crc16_gen_tb.sv
module quad_crc16_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 10;
  localparam int NTV    = 6;

  localparam logic [31:0] TV_WORDS [NTV][4] = '{
    '{32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000},
    '{32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h00000000},
    '{32'h31333934, 32'h12345678, 32'h00000000, 32'h00000000},
    '{32'hDEADBEEF, 32'h00000001, 32'h80000000, 32'h0F0F0F0F},
    '{32'hA5A5A5A5, 32'h5A5A5A5A, 32'h00FF00FF, 32'h00000000},
    '{32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98, 32'h76543210}
  };
  localparam int TV_LEN [NTV] = '{1, 1, 2, 4, 3, 4};
  localparam bit TV_GAP [NTV] = '{0, 0, 0, 0, 1, 1};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [LEN_W-1:0]  len_i = '0;
  logic              valid_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic              busy_o;
  logic              done_o;
  logic [15:0]       crc_o;

  int total = 0;
  int bad   = 0;

  quad_crc16_gen #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
    .valid_i(valid_i), .data_i(data_i),
    .busy_o(busy_o), .done_o(done_o), .crc_o(crc_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] ref_fold(logic [15:0] c, logic [31:0] q);
    logic [15:0] r = c;
    for (int i = 31; i >= 0; i--) begin
      logic fb = r[15] ^ q[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [31:0] word_of(int idx, int k);
    if (idx >= 0) return TV_WORDS[idx][k];
    return (32'(k) * 32'h9E3779B9) ^ 32'h13579BDF;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_block(int idx, int n, bit gap);
    logic [15:0] e = 16'h0;
    @(negedge clk); start_i = 1'b1; len_i = LEN_W'(n); valid_i = 1'b1; data_i = 32'hCAFEF00D;
    @(negedge clk); start_i = 1'b0; valid_i = 1'b0;
    chk(busy_o == (n != 0), "R2 busy", 32'(busy_o), 32'(n != 0));
    chk(crc_o == 16'h0, "R2 clear", 32'(crc_o), 0);
    if (n == 0) begin
      chk(done_o == 1'b1, "R7 done", 32'(done_o), 1);
    end else begin
      for (int k = 0; k < n; k++) begin
        logic [31:0] w = word_of(idx, k);
        e = ref_fold(e, w);
        if (gap && (k % 2 == 1)) begin
          valid_i = 1'b0; data_i = ~w;
          @(negedge clk);
          chk(done_o == 1'b0 && busy_o, "R4 stall", 32'(done_o), 0);
        end
        valid_i = 1'b1; data_i = w;
        @(negedge clk);
        if (k < n - 1 && done_o) chk(1'b0, "R5 early", 32'(done_o), 0);
      end
      valid_i = 1'b0;
      chk(done_o == 1'b1, "R5 done", 32'(done_o), 1);
      chk(busy_o == 1'b0, "R5 busy", 32'(busy_o), 0);
      chk(crc_o == e, (n > 1000) ? "R9 crc" : "R3 crc", 32'(crc_o), 32'(e));
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R5 pulse", 32'(done_o), 0);
    chk(crc_o == e, "R6 hold", 32'(crc_o), 32'(e));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] held;
    logic [15:0] e2;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy_o == 0 && done_o == 0 && crc_o == 0, "R1 reset", {busy_o, done_o, 14'h0, crc_o}, 0);
    rst = 1'b0;

    // table walk (R3, R4)
    for (int t = 0; t < NTV; t++) run_block(t, TV_LEN[t], TV_GAP[t]);

    // R6: idle data ignored
    held = crc_o;
    for (int k = 0; k < 3; k++) begin
      valid_i = 1'b1; data_i = 32'h5555AAAA + 32'(k);
      @(negedge clk);
      chk(crc_o == held && done_o == 0, "R6 idle", 32'(crc_o), 32'(held));
    end
    valid_i = 1'b0;

    // R7: zero length
    run_block(-1, 0, 0);

    // R8: restart mid-block
    @(negedge clk); start_i = 1'b1; len_i = 3;
    @(negedge clk); start_i = 1'b0; valid_i = 1'b1; data_i = 32'h11112222;
    @(negedge clk); start_i = 1'b1; len_i = 2; data_i = 32'h33334444;
    @(negedge clk); start_i = 1'b0; data_i = 32'h55556666;
    @(negedge clk); data_i = 32'h77778888;
    chk(done_o == 0, "R8 count", 32'(done_o), 0);
    @(negedge clk); valid_i = 1'b0;
    e2 = ref_fold(ref_fold(16'h0, 32'h55556666), 32'h77778888);
    chk(done_o == 1 && crc_o == e2, "R8 restart", 32'(crc_o), 32'(e2));

    // R9: long speed-map sized block
    run_block(-1, 1009, 0);

    // R1: reset during a block
    @(negedge clk); start_i = 1'b1; len_i = 2;
    @(negedge clk); start_i = 1'b0; valid_i = 1'b1; data_i = 32'hABCDEF01;
    @(negedge clk); rst = 1'b1; valid_i = 1'b0;
    @(negedge clk); rst = 1'b0;
    chk(busy_o == 0 && done_o == 0 && crc_o == 0, "R1 midreset", 32'(crc_o), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule